// File: doc/BRIEF.md
# Saturating Fixed-Point ALU with Sticky Status

This block is the fixed-point arithmetic and logic stage of a DSP datapath. A single issue strobe presents two signed operands, an operation code and a saturation-mode bit. On the next clock edge the block registers a result, a live status word and a sticky status word. It supports addition, subtraction, compare, signed average, and the bitwise AND, OR and XOR. A paired mode returns the sum and the difference of one operand pair in the same cycle. With saturation enabled, an overflowing sum or difference is clamped to the most positive or most negative code. With saturation disabled, it wraps.

The live status word holds zero, negative, overflow, carry and a floating-point invalid bit. Each accepted operation refreshes it. The invalid bit always reads as cleared, because every operation here is integer. The sticky word collects overflow and invalid events until software rewrites it through a dedicated write strobe. A greater-or-equal output is derived from the live flags, so a conditional step after a compare can test it directly.

Top module: `sat_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res`, `res_diff`, `status` and `sticky` become zero.
- R2: Operation codes are 0 add, 1 subtract, 2 compare, 3 average, 4 AND, 5 OR, 6 XOR, 7 paired. An accepted add or subtract writes A+B or A−B modulo 2^WIDTH to `res` one cycle after `op_valid`. The carry flag is set for add when the unsigned sum carries out, and for subtract when A ≥ B unsigned (no borrow).
- R3: The overflow flag is set when the signed sum or difference leaves the WIDTH-bit range. With `sat_en` high, such a result is written as the most positive code (0111…1) when the true value is positive and as the most negative code (100…0) when it is negative.
- R4: `status` bit 0 is zero, bit 1 is negative, bit 2 is overflow, bit 3 is carry and bit 4 is invalid. Zero and negative describe the wrapped two's-complement result whether or not saturation applies.
- R5: Compare sets the flags exactly as a subtract would and leaves `res` and `res_diff` unchanged. After it, `ge` equals 1 exactly when A ≥ B as signed numbers, where `ge` is NOT(negative XOR overflow).
- R6: Average writes floor((A+B)/2) of the signed operands, computed on a WIDTH+1-bit sum so that nothing is lost. Overflow is cleared, and carry is the unsigned carry out of A+B.
- R7: AND, OR and XOR write the bitwise result and clear the carry and overflow flags.
- R8: The paired operation writes A+B to `res` and A−B to `res_diff`, each saturated on its own when `sat_en` is high. Zero, negative and carry describe the sum, and overflow is the OR of the overflows of the two lanes. Only the paired operation updates `res_diff`.
- R9: The invalid flag (`status` bit 4) is cleared by every accepted operation.
- R10: `sticky` bit 0 collects overflow and bit 1 collects invalid. A set bit stays set through later operations. It changes only when `stk_wr` is high, and then `sticky` loads `stk_wdata`. This write takes priority over a concurrent operation.
- R11: When `op_valid` is low, `res`, `res_diff` and `status` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for the operation on the other inputs |
| op_code | input | 3 | Operation select |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| opa | input | WIDTH | Operand A (two's complement) |
| opb | input | WIDTH | Operand B (two's complement) |
| stk_wr | input | 1 | Sticky register write strobe |
| stk_wdata | input | 2 | Value loaded into the sticky register |
| res | output | WIDTH | Registered main result |
| res_diff | output | WIDTH | Registered difference lane of the paired operation |
| status | output | 5 | Live flags {invalid, carry, overflow, negative, zero} |
| sticky | output | 2 | Accumulated {invalid, overflow} |
| ge | output | 1 | Signed greater-or-equal derived from the live flags |

## Verification
The bench sweeps every operand pair of a 4-bit configuration through every operation in both overflow modes, so each of the following is reached.

- **Clamp direction.** Both overflow directions are exercised, including the most-negative-plus-most-negative case. A design that picks the clamp from the wrapped sign would return the wrong extreme.
- **Flags under saturation.** A design that derives zero and negative from the saturated value breaks `ge` after an overflowing compare.
- **Subtract carry.** A design that reports borrow instead of no-borrow is caught.
- **Average at the extremes.** A design that drops the extra sum bit gets a wrong result here.
- **Paired overflow.** A design that ORs only one lane into the overflow flag is caught.
- **Results left alone.** Compare and idle cycles must leave the results untouched.
- **Sticky behaviour.** The sticky bits are checked across overflowing and clean operations and across direct writes, so a sticky bit that tracks the live flag is caught.

// File: rtl/sat_alu_pkg.sv
`timescale 1ns/1ps
package sat_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_AVG  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_DUAL = 3'd7
    } alu_op_e;

    // bit 0 zero .. bit 4 invalid
    typedef struct packed {
        logic inv;
        logic c;
        logic v;
        logic n;
        logic z;
    } alu_flags_t;

    localparam int FLAG_W   = $bits(alu_flags_t);
    localparam int STICKY_W = 2;
    localparam int STK_OVF  = 0;
    localparam int STK_INV  = 1;
    localparam int LANES    = 2;   // 0 = sum lane, 1 = difference lane

    function automatic logic is_logic_op(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic writes_result(input alu_op_e op);
        return op != OP_CMP;
    endfunction

    function automatic alu_flags_t make_flags(input logic zero, input logic neg,
                                              input logic ovf, input logic cry);
        alu_flags_t f;
        f.z   = zero;
        f.n   = neg;
        f.v   = ovf;
        f.c   = cry;
        f.inv = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/sat_alu_clamp.sv
`timescale 1ns/1ps
module sat_alu_clamp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   ext_val,
    input  logic             sat_en,
    output logic [WIDTH-1:0] out_val,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        ovf = ext_val[WIDTH] ^ ext_val[WIDTH-1];
        if (sat_en && ovf)
            out_val = ext_val[WIDTH] ? NEG_MIN : POS_MAX;
        else
            out_val = ext_val[WIDTH-1:0];
    end
endmodule

// File: rtl/sat_alu_addsub.sv
`timescale 1ns/1ps
module sat_alu_addsub
    import sat_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sat_en,
    output logic [WIDTH-1:0] lane_sat [LANES],
    output logic [WIDTH-1:0] lane_raw [LANES],
    output logic             lane_ovf [LANES],
    output logic             lane_cry [LANES],
    output logic [WIDTH-1:0] avg_val
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] ext_val [LANES];

    assign a_ext = {a[WIDTH-1], a};
    assign b_ext = {b[WIDTH-1], b};

    // sum lane and difference lane (a + ~b + 1), both sign-extended
    assign ext_val[0] = a_ext + b_ext;
    assign ext_val[1] = a_ext + ~b_ext + {{(EXT_W-1){1'b0}}, 1'b1};

    // unsigned carry out recovered from the extended top bit
    assign lane_cry[0] = ext_val[0][WIDTH] ^ a[WIDTH-1] ^ b[WIDTH-1];
    assign lane_cry[1] = ext_val[1][WIDTH] ^ a[WIDTH-1] ^ ~b[WIDTH-1];

    // signed average keeps the bit above the word
    assign avg_val = ext_val[0][WIDTH:1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_raw[g] = ext_val[g][WIDTH-1:0];
        sat_alu_clamp #(.WIDTH(WIDTH)) u_clamp (
            .ext_val (ext_val[g]),
            .sat_en  (sat_en),
            .out_val (lane_sat[g]),
            .ovf     (lane_ovf[g])
        );
    end
endmodule

// File: rtl/sat_alu_status.sv
`timescale 1ns/1ps
module sat_alu_status
    import sat_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  alu_flags_t          nxt_flags,
    input  logic                stk_wr,
    input  logic [STICKY_W-1:0] stk_wdata,
    output alu_flags_t          flags_q,
    output logic [STICKY_W-1:0] sticky_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (upd)
            flags_q <= nxt_flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
        end else if (stk_wr) begin
            sticky_q <= stk_wdata;
        end else if (upd) begin
            sticky_q[STK_OVF] <= sticky_q[STK_OVF] | nxt_flags.v;
            sticky_q[STK_INV] <= sticky_q[STK_INV] | nxt_flags.inv;
        end
    end

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (sticky_q[STK_OVF] && !stk_wr) |=> sticky_q[STK_OVF]);

    assert_sticky_load_R10: assert property (@(posedge clk) disable iff (rst)
        stk_wr |=> (sticky_q == $past(stk_wdata)));

    assert_invalid_clear_R9: assert property (@(posedge clk) disable iff (rst)
        upd |=> !flags_q.inv);

    assert_idle_flags_R11: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(flags_q));
endmodule

// File: rtl/sat_alu.sv
`timescale 1ns/1ps
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic                sat_en,
    input  logic [WIDTH-1:0]    opa,
    input  logic [WIDTH-1:0]    opb,
    input  logic                stk_wr,
    input  logic [STICKY_W-1:0] stk_wdata,
    output logic [WIDTH-1:0]    res,
    output logic [WIDTH-1:0]    res_diff,
    output logic [FLAG_W-1:0]   status,
    output logic [STICKY_W-1:0] sticky,
    output logic                ge
);
    localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    alu_op_e          op;
    logic [WIDTH-1:0] lane_sat [LANES];
    logic [WIDTH-1:0] lane_raw [LANES];
    logic             lane_ovf [LANES];
    logic             lane_cry [LANES];
    logic [WIDTH-1:0] avg_val;
    logic [WIDTH-1:0] bit_val;

    logic [WIDTH-1:0] res_nxt;
    logic [WIDTH-1:0] raw_nxt;
    logic             v_nxt;
    logic             c_nxt;
    alu_flags_t       flags_nxt;
    alu_flags_t       flags_q;

    logic [WIDTH-1:0] res_q;
    logic [WIDTH-1:0] diff_q;

    assign op = alu_op_e'(op_code);

    sat_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (opa),
        .b        (opb),
        .sat_en   (sat_en),
        .lane_sat (lane_sat),
        .lane_raw (lane_raw),
        .lane_ovf (lane_ovf),
        .lane_cry (lane_cry),
        .avg_val  (avg_val)
    );

    always_comb begin
        unique case (op)
            OP_AND:  bit_val = opa & opb;
            OP_OR:   bit_val = opa | opb;
            default: bit_val = opa ^ opb;
        endcase
    end

    always_comb begin
        res_nxt = lane_sat[0];
        raw_nxt = lane_raw[0];
        v_nxt   = lane_ovf[0];
        c_nxt   = lane_cry[0];
        unique case (op)
            OP_ADD: ;
            OP_SUB, OP_CMP: begin
                res_nxt = lane_sat[1];
                raw_nxt = lane_raw[1];
                v_nxt   = lane_ovf[1];
                c_nxt   = lane_cry[1];
            end
            OP_AVG: begin
                res_nxt = avg_val;
                raw_nxt = avg_val;
                v_nxt   = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_nxt = bit_val;
                raw_nxt = bit_val;
                v_nxt   = 1'b0;
                c_nxt   = 1'b0;
            end
            OP_DUAL: v_nxt = lane_ovf[0] | lane_ovf[1];
            default: ;
        endcase
        flags_nxt = make_flags(raw_nxt == '0, raw_nxt[WIDTH-1], v_nxt, c_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            diff_q <= '0;
        end else if (op_valid) begin
            if (writes_result(op))
                res_q <= res_nxt;
            if (op == OP_DUAL)
                diff_q <= lane_sat[1];
        end
    end

    sat_alu_status u_status (
        .clk       (clk),
        .rst       (rst),
        .upd       (op_valid),
        .nxt_flags (flags_nxt),
        .stk_wr    (stk_wr),
        .stk_wdata (stk_wdata),
        .flags_q   (flags_q),
        .sticky_q  (sticky)
    );

    assign res      = res_q;
    assign res_diff = diff_q;
    assign status   = flags_q;
    assign ge       = ~(flags_q.n ^ flags_q.v);

    assert_cmp_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CMP) |=> ($stable(res_q) && $stable(diff_q)));

    assert_logic_no_cv_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic_op(op)) |=> (!flags_q.c && !flags_q.v));

    assert_sat_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sat_en && op == OP_ADD && lane_ovf[0])
            |=> (res_q == POS_MAX || res_q == NEG_MIN));

    assert_diff_only_dual_R8: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op != OP_DUAL) |=> $stable(diff_q));

    assert_idle_result_R11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_q));
endmodule

// File: tb/tb_sat_alu.sv
`timescale 1ns/1ps
module tb_sat_alu;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic         sat_en = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         stk_wr = 1'b0;
    logic [1:0]   stk_wdata = 2'b00;
    logic [W-1:0] res;
    logic [W-1:0] res_diff;
    logic [4:0]   status;
    logic [1:0]   sticky;
    logic         ge;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int   e_res = 0, e_diff = 0;
    logic [4:0] e_stat = '0;
    logic [1:0] e_stk  = '0;

    always #5 clk = ~clk;

    sat_alu #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .sat_en(sat_en), .opa(opa), .opb(opb), .stk_wr(stk_wr),
        .stk_wdata(stk_wdata), .res(res), .res_diff(res_diff),
        .status(status), .sticky(sticky), .ge(ge)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sgn(input int u);
        return (u >= M/2) ? u - M : u;
    endfunction

    function automatic int clampv(input int t, input bit sat);
        if (sat && t > M/2 - 1) return M/2 - 1;
        if (sat && t < -M/2)    return M/2;
        return ((t % M) + M) % M;
    endfunction

    task automatic run_op(input int op, input int a, input int b, input bit sat);
        int sa, sb, st, dt, raw, c, v, at;
        string tag;
        sa = sgn(a); sb = sgn(b);
        st = sa + sb; dt = sa - sb;
        raw = 0; c = 0; v = 0; tag = "R2";
        case (op)
            0: begin raw = (a+b)%M; c = (a+b) >= M; v = (st >= M/2 || st < -M/2);
                     e_res = clampv(st, sat); tag = v ? "R3" : "R2"; end
            1, 2: begin raw = (a-b+M)%M; c = (a >= b); v = (dt >= M/2 || dt < -M/2);
                     if (op == 1) e_res = clampv(dt, sat);
                     tag = (op == 2) ? "R5" : (v ? "R3" : "R2"); end
            3: begin at = st >>> 1; raw = ((at % M) + M) % M; c = (a+b) >= M;
                     e_res = raw; tag = "R6"; end
            4: begin raw = a & b; e_res = raw; tag = "R7"; end
            5: begin raw = a | b; e_res = raw; tag = "R7"; end
            6: begin raw = a ^ b; e_res = raw; tag = "R7"; end
            default: begin raw = (a+b)%M; c = (a+b) >= M;
                     v = (st >= M/2 || st < -M/2) || (dt >= M/2 || dt < -M/2);
                     e_res = clampv(st, sat); e_diff = clampv(dt, sat); tag = "R8"; end
        endcase
        // R4 layout {inv,c,v,n,z}; R9 inv always 0
        e_stat = {1'b0, c[0], v[0], raw >= M/2, raw == 0};
        e_stk[0] = e_stk[0] | v[0];
        @(negedge clk);
        op_valid = 1'b1; op_code = op[2:0]; opa = a[W-1:0]; opb = b[W-1:0]; sat_en = sat;
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk({res, res_diff, status, sticky} == {e_res[W-1:0], e_diff[W-1:0], e_stat, e_stk},
            tag, {res, res_diff, status, sticky},
            {e_res[W-1:0], e_diff[W-1:0], e_stat, e_stk});
        if (op == 2) chk(ge == (sa >= sb), "R5 ge", ge, sa >= sb);
    endtask

    task automatic write_sticky(input logic [1:0] val);
        @(negedge clk);
        stk_wr = 1'b1; stk_wdata = val;
        @(posedge clk); #1;
        stk_wr = 1'b0;
        e_stk = val;
        chk(sticky == val, "R10 write", sticky, val);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset values
        chk({res, res_diff, status, sticky} == '0, "R1", {res, res_diff, status, sticky}, 0);

        // R10 sticky holds, then clears only by write
        run_op(0, 7, 1, 1'b0);                 // overflow sets sticky
        chk(sticky[0] == 1'b1, "R10 set", sticky, 1);
        run_op(0, 1, 1, 1'b0);                 // clean op, sticky stays
        chk(sticky[0] == 1'b1, "R10 hold", sticky, 1);
        write_sticky(2'b00);
        write_sticky(2'b10);
        write_sticky(2'b00);

        // R11 idle cycle: inputs change, nothing moves
        run_op(7, 5, 2, 1'b0);
        @(negedge clk);
        op_code = 3'd0; opa = 4'd9; opb = 4'd3; sat_en = 1'b1;
        @(posedge clk); #1;
        chk({res, res_diff, status} == {e_res[W-1:0], e_diff[W-1:0], e_stat}, "R11",
            {res, res_diff, status}, {e_res[W-1:0], e_diff[W-1:0], e_stat});

        // exhaustive sweep of the small configuration
        for (int s = 0; s < 2; s++)
            for (int op = 0; op < 8; op++)
                for (int a = 0; a < M; a++)
                    for (int b = 0; b < M; b++)
                        run_op(op, a, b, s[0]);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule